// File: doc/BRIEF.md
# ADC Conversion Sequencer with Sample Accumulator

This block is the digital control layer that sits beside a 12-bit successive-approximation converter core. It chooses which event starts a sequence: a software start strobe, a periodic timer overflow pulse, or a rising edge on an asynchronous external pin. It then asks the core for one, four, eight or sixteen samples over a start/done/data handshake and adds them in a hardware accumulator. When the last sample arrives, the block latches the sum as the result, sets a sticky completion flag, and evaluates a window comparison on the full sum.

In burst mode the core is kept in its low-power state while the block is idle. A single trigger powers the core up and waits a configurable settling time. The block then collects every programmed sample and powers the core down again, with no software action in between. The window comparison can flag results that fall inside an inclusive range or results that fall outside it. Software can therefore watch a voltage in the background and take an interrupt only when the condition holds.

Top module: `adc_seq`

## Requirements
- R1: `trig_sel` picks the trigger source: 0 = `sw_start` pulse, 1 = `tmr_ovf` pulse, 2 = rising edge of `ext_cnv` after a two-flop synchronizer. Pulses on the sources that are not selected start nothing.
- R2: A rising edge on `ext_cnv` starts exactly one sequence, even if the pin then stays high.
- R3: `avg_code` sets the number of `core_start` requests per sequence: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16.
- R4: `result` is the 16-bit sum of all samples of the sequence. It changes only on the clock edge where `busy` falls.
- R5: `busy` is high from the edge that accepts a trigger until the edge that latches the result. Triggers that arrive while `busy` is high are ignored.
- R6: `done_flag` is set when the result is latched and stays set until `clr_done` is pulsed. `irq_done` equals `done_flag` AND `done_ie`.
- R7: With `burst_en` = 1, `core_pwr` is low while idle and high during a sequence. The first `core_start` of a sequence comes exactly `settle_len`+1 cycles after `core_pwr` rises. With `burst_en` = 0, `core_pwr` stays high.
- R8: The window compares the full accumulated result against inclusive bounds. With `win_outside` = 0 a hit means `win_lo` <= result <= `win_hi`; with `win_outside` = 1 a hit is the opposite. A hit sets `win_flag`, which stays set until `clr_win` is pulsed. `irq_win` equals `win_flag` AND `win_ie`.
- R9: The accumulator clears at the start of every sequence, so no earlier sum carries into a new result.
- R10: `core_start` is a single-cycle pulse, issued only while `core_pwr` is high. The next request follows only after `core_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_sel | input | 2 | Trigger source select |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_cnv | input | 1 | Asynchronous external convert-start pin |
| avg_code | input | 2 | Samples per sequence code |
| burst_en | input | 1 | Burst mode with automatic power sequencing |
| settle_len | input | 8 | Settling cycles after power-up |
| win_lo | input | 16 | Inclusive lower window bound |
| win_hi | input | 16 | Inclusive upper window bound |
| win_outside | input | 1 | 0 = hit inside window, 1 = hit outside |
| done_ie | input | 1 | Completion interrupt enable |
| win_ie | input | 1 | Window interrupt enable |
| clr_done | input | 1 | Clear completion flag |
| clr_win | input | 1 | Clear window flag |
| core_pwr | output | 1 | Converter core power enable |
| core_start | output | 1 | Sample request to core |
| core_done | input | 1 | Sample valid from core |
| core_data | input | 12 | Sample value from core |
| busy | output | 1 | Sequence in progress |
| result | output | 16 | Latched accumulated result |
| done_flag | output | 1 | Sticky completion flag |
| win_flag | output | 1 | Sticky window hit flag |
| irq_done | output | 1 | Completion interrupt |
| irq_win | output | 1 | Window interrupt |

## Verification
A trigger on the software or timer source is accepted on the next clock edge. An external edge takes two more edges to cross the synchronizer. The result, `done_flag`, `win_flag` and the fall of `busy` all land on the single edge that follows the last `core_done`. The bench therefore waits for `done_flag` and reads all four together at the following falling edge. The bench times the burst settling gap from the clock edge where `core_pwr` is first seen high to the edge where the first `core_start` is seen, and expects `settle_len`+1. Each check that a trigger is ignored waits several cycles past the point where an accepted trigger would have raised `busy` or issued a request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_ACC_SHIFT = 4;
    localparam int DEF_SETTLE_W = 8;
    localparam int CNT_W = DEF_ACC_SHIFT + 1;

    typedef enum logic [1:0] {
        SRC_SW  = 2'd0,
        SRC_TMR = 2'd1,
        SRC_EXT = 2'd2
    } trig_src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT,
        ST_LATCH
    } seq_state_e;

    typedef enum logic {
        WIN_INSIDE  = 1'b0,
        WIN_OUTSIDE = 1'b1
    } win_mode_e;

    // samples per sequence for each configuration code
    function automatic logic [CNT_W-1:0] samples_for(input logic [1:0] code);
        case (code)
            2'd0:    samples_for = CNT_W'(1);
            2'd1:    samples_for = CNT_W'(4);
            2'd2:    samples_for = CNT_W'(8);
            default: samples_for = CNT_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/adc_trig.sv
module adc_trig
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    input  logic       sw_start,
    input  logic       tmr_ovf,
    input  logic       ext_pin,
    output logic       trig
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             ext_rise;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN-2:0], ext_pin};
    end

    assign ext_rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

    always_comb begin
        case (trig_src_e'(sel))
            SRC_SW:  trig = sw_start;
            SRC_TMR: trig = tmr_ovf;
            SRC_EXT: trig = ext_rise;
            default: trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_window.sv
module adc_window
    import adc_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  win_mode_e    mode,
    output logic         hit
);
    logic in_range;
    assign in_range = (value >= lo) && (value <= hi);
    assign hit = (mode == WIN_OUTSIDE) ? ~in_range : in_range;
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int ACC_W    = DEF_SAMPLE_W + DEF_ACC_SHIFT,
    parameter int SETTLE_W = DEF_SETTLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic [1:0]          avg_code,
    input  logic                burst_en,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                core_done,
    input  logic [SAMPLE_W-1:0] core_data,
    output logic                core_pwr,
    output logic                core_start,
    output logic                busy,
    output logic                latch_en,
    output logic [ACC_W-1:0]    acc
);
    localparam int PAD = ACC_W - SAMPLE_W;

    seq_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic [1:0]          avg_q;
    logic [SETTLE_W-1:0] settle_cnt;
    logic [CNT_W-1:0]    last_idx;

    assign last_idx = samples_for(avg_q) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            acc        <= '0;
            cnt        <= '0;
            avg_q      <= '0;
            settle_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (trig) begin
                        acc        <= '0;
                        cnt        <= '0;
                        avg_q      <= avg_code;
                        settle_cnt <= settle_len;
                        state      <= burst_en ? ST_SETTLE : ST_REQ;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == '0) state <= ST_REQ;
                    else                  settle_cnt <= settle_cnt - SETTLE_W'(1);
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: begin
                    if (core_done) begin
                        acc   <= acc + {{PAD{1'b0}}, core_data};
                        cnt   <= cnt + CNT_W'(1);
                        state <= (cnt == last_idx) ? ST_LATCH : ST_REQ;
                    end
                end
                ST_LATCH: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign core_start = (state == ST_REQ);
    assign latch_en   = (state == ST_LATCH);
    assign core_pwr   = ~burst_en | busy;
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W  = DEF_SAMPLE_W,
    parameter int ACC_SHIFT = DEF_ACC_SHIFT,
    parameter int SETTLE_W  = DEF_SETTLE_W,
    localparam int ACC_W    = SAMPLE_W + ACC_SHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          trig_sel,
    input  logic                sw_start,
    input  logic                tmr_ovf,
    input  logic                ext_cnv,
    input  logic [1:0]          avg_code,
    input  logic                burst_en,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic [ACC_W-1:0]    win_lo,
    input  logic [ACC_W-1:0]    win_hi,
    input  logic                win_outside,
    input  logic                done_ie,
    input  logic                win_ie,
    input  logic                clr_done,
    input  logic                clr_win,
    output logic                core_pwr,
    output logic                core_start,
    input  logic                core_done,
    input  logic [SAMPLE_W-1:0] core_data,
    output logic                busy,
    output logic [ACC_W-1:0]    result,
    output logic                done_flag,
    output logic                win_flag,
    output logic                irq_done,
    output logic                irq_win
);
    logic             trig;
    logic             latch_en;
    logic             hit;
    logic [ACC_W-1:0] acc;

    adc_trig #(.SYNC_STAGES(2)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .sel      (trig_sel),
        .sw_start (sw_start),
        .tmr_ovf  (tmr_ovf),
        .ext_pin  (ext_cnv),
        .trig     (trig)
    );

    adc_ctrl #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .SETTLE_W (SETTLE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .avg_code   (avg_code),
        .burst_en   (burst_en),
        .settle_len (settle_len),
        .core_done  (core_done),
        .core_data  (core_data),
        .core_pwr   (core_pwr),
        .core_start (core_start),
        .busy       (busy),
        .latch_en   (latch_en),
        .acc        (acc)
    );

    adc_window #(.W(ACC_W)) u_win (
        .value (acc),
        .lo    (win_lo),
        .hi    (win_hi),
        .mode  (win_mode_e'(win_outside)),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            done_flag <= 1'b0;
            win_flag  <= 1'b0;
        end else begin
            if (latch_en) result <= acc;
            if (latch_en)      done_flag <= 1'b1;
            else if (clr_done) done_flag <= 1'b0;
            if (latch_en && hit) win_flag <= 1'b1;
            else if (clr_win)    win_flag <= 1'b0;
        end
    end

    assign irq_done = done_flag & done_ie;
    assign irq_win  = win_flag & win_ie;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             core_pwr,
    input logic             core_start,
    input logic             core_done,
    input logic             busy,
    input logic             done_flag,
    input logic             win_flag,
    input logic             clr_done,
    input logic             clr_win,
    input logic [ACC_W-1:0] result
);
    // R10
    start_powered_chk: assert property (@(posedge clk) disable iff (rst)
        core_start |-> core_pwr);

    // R10
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(result));

    // R5
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $fell(busy));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !clr_done) |=> done_flag);

    // R8
    win_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (win_flag && !clr_win) |=> win_flag);

    // R10
    done_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (core_done && !busy) |-> !core_start);
endmodule

bind adc_seq adc_seq_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_pwr   (core_pwr),
    .core_start (core_start),
    .core_done  (core_done),
    .busy       (busy),
    .done_flag  (done_flag),
    .win_flag   (win_flag),
    .clr_done   (clr_done),
    .clr_win    (clr_win),
    .result     (result)
);

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  trig_sel = 2'd0;
    logic        sw_start = 1'b0;
    logic        tmr_ovf = 1'b0;
    logic        ext_cnv = 1'b0;
    logic [1:0]  avg_code = 2'd0;
    logic        burst_en = 1'b0;
    logic [7:0]  settle_len = 8'd0;
    logic [15:0] win_lo = 16'd0;
    logic [15:0] win_hi = 16'd0;
    logic        win_outside = 1'b0;
    logic        done_ie = 1'b0;
    logic        win_ie = 1'b0;
    logic        clr_done = 1'b0;
    logic        clr_win = 1'b0;
    logic        core_pwr, core_start;
    logic        core_done = 1'b0;
    logic [11:0] core_data = 12'd0;
    logic        busy, done_flag, win_flag, irq_done, irq_win;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_seq dut (
        .clk(clk), .rst(rst), .trig_sel(trig_sel), .sw_start(sw_start),
        .tmr_ovf(tmr_ovf), .ext_cnv(ext_cnv), .avg_code(avg_code),
        .burst_en(burst_en), .settle_len(settle_len), .win_lo(win_lo),
        .win_hi(win_hi), .win_outside(win_outside), .done_ie(done_ie),
        .win_ie(win_ie), .clr_done(clr_done), .clr_win(clr_win),
        .core_pwr(core_pwr), .core_start(core_start), .core_done(core_done),
        .core_data(core_data), .busy(busy), .result(result),
        .done_flag(done_flag), .win_flag(win_flag), .irq_done(irq_done),
        .irq_win(irq_win)
    );

    // behavioural converter stub: answers each request after a fixed latency
    int  stub_idx = 0;
    int  lat_cnt = 0;
    bit  pending = 0;
    int  start_cnt = 0;
    int  cyc = 0;
    int  t_pwr = 0;
    int  gap = -1;
    bit  armed = 0;
    bit  pwr_q = 1;

    function automatic int sample_of(input int i);
        return (i * 733 + 91) & 12'hFFF;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        core_done <= 1'b0;
        pwr_q <= core_pwr;
        if (core_pwr && !pwr_q) begin
            t_pwr <= cyc;
            armed <= 1;
        end
        if (core_start) begin
            start_cnt <= start_cnt + 1;
            if (armed) begin
                gap <= cyc - t_pwr;
                armed <= 0;
            end
        end
        if (rst) begin
            pending <= 0;
        end else if (core_start) begin
            pending <= 1;
            lat_cnt <= 2;
        end else if (pending) begin
            if (lat_cnt == 0) begin
                core_done <= 1'b1;
                core_data <= 12'(sample_of(stub_idx));
                stub_idx  <= stub_idx + 1;
                pending   <= 0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_flags();
        clr_done = 1'b1;
        clr_win  = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        clr_win  = 1'b0;
    endtask

    task automatic fire(input int src);
        case (src)
            0: begin sw_start = 1'b1; @(negedge clk); sw_start = 1'b0; end
            1: begin tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0; end
            default: begin ext_cnv = 1'b1; repeat (3) @(negedge clk); ext_cnv = 1'b0; end
        endcase
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_flag && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    function automatic int n_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int clamp16(input int v);
        if (v < 0) return 0;
        if (v > 65535) return 65535;
        return v;
    endfunction

    task automatic run_seq(input int src, input int avg, input bit burst, input int settle,
                           input bit outside, input int lo_off, input int hi_off, input bit die);
        int n, base, s0, expsum, lo, hi;
        bit in_r, exp_hit;
        n = n_of(avg);
        base = stub_idx;
        s0 = start_cnt;
        expsum = 0;
        for (int i = 0; i < n; i++) expsum += sample_of(base + i);
        lo = clamp16(expsum + lo_off);
        hi = clamp16(expsum + hi_off);
        in_r = (expsum >= lo) && (expsum <= hi);
        exp_hit = outside ? !in_r : in_r;
        trig_sel = 2'(src);
        avg_code = 2'(avg);
        burst_en = burst;
        settle_len = 8'(settle);
        win_lo = 16'(lo);
        win_hi = 16'(hi);
        win_outside = outside;
        done_ie = die;
        win_ie = 1'b1;
        clear_flags();
        @(negedge clk);
        if (burst) chk(core_pwr == 1'b0, "R7 idle power off", core_pwr, 0);
        fire(src);
        wait_done();
        chk(done_flag == 1'b1, "R6 done flag set", done_flag, 1);
        chk(result == 16'(expsum), "R4 accumulated result", result, expsum);
        chk(start_cnt - s0 == n, "R3 request count", start_cnt - s0, n);
        chk(busy == 1'b0, "R5 busy low at latch", busy, 0);
        chk(win_flag == exp_hit, "R8 window hit", win_flag, exp_hit);
        chk(irq_win == exp_hit, "R8 window irq", irq_win, exp_hit);
        chk(irq_done == die, "R6 done irq enable", irq_done, die);
        if (burst) begin
            chk(gap == settle + 1, "R7 settle gap", gap, settle + 1);
            chk(core_pwr == 1'b0, "R7 power off after burst", core_pwr, 0);
        end else begin
            chk(core_pwr == 1'b1, "R7 power on in normal mode", core_pwr, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, r_first;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R5 reset busy", busy, 0);
        chk(result == 16'd0, "R4 reset result", result, 0);
        chk(done_flag == 1'b0, "R6 reset done flag", done_flag, 0);
        chk(win_flag == 1'b0, "R8 reset window flag", win_flag, 0);

        // sweep: every source, sample count and power mode
        for (int k = 0; k < 24; k++) begin
            int lo_o, hi_o;
            case (k % 4)
                0: begin lo_o = 0;  hi_o = 0;  end
                1: begin lo_o = 1;  hi_o = 5;  end
                2: begin lo_o = -5; hi_o = -1; end
                default: begin lo_o = -3; hi_o = 3; end
            endcase
            run_seq(k / 8, (k / 2) % 4, k % 2, (k % 4) * 3, (k / 4) % 2, lo_o, hi_o, (k / 3) % 2);
            repeat (2) @(negedge clk);
        end

        // R1: non-selected sources start nothing
        trig_sel = 2'd0;
        burst_en = 1'b0;
        clear_flags();
        s0 = start_cnt;
        fire(1);
        fire(2);
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R1 unselected source busy", busy, 0);
        chk(start_cnt - s0 == 0, "R1 unselected source requests", start_cnt - s0, 0);
        chk(done_flag == 1'b0, "R1 unselected source done", done_flag, 0);

        // R5: trigger during busy ignored
        avg_code = 2'd3;
        s0 = start_cnt;
        fire(0);
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R5 busy mid sequence", busy, 1);
        fire(0);
        wait_done();
        repeat (10) @(negedge clk);
        chk(start_cnt - s0 == 16, "R5 retrigger ignored", start_cnt - s0, 16);
        chk(busy == 1'b0, "R5 no second sequence", busy, 0);

        // R6: sticky done flag and clear
        chk(done_flag == 1'b1, "R6 flag sticky", done_flag, 1);
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        chk(done_flag == 1'b0, "R6 flag cleared", done_flag, 0);
        chk(irq_done == 1'b0, "R6 irq cleared", irq_done, 0);

        // R8: window flag sticky until clr_win (force a hit with full range)
        win_lo = 16'd0;
        win_hi = 16'hFFFF;
        win_outside = 1'b0;
        avg_code = 2'd0;
        fire(0);
        wait_done();
        repeat (5) @(negedge clk);
        chk(win_flag == 1'b1, "R8 window flag sticky", win_flag, 1);
        clr_win = 1'b1;
        @(negedge clk);
        clr_win = 1'b0;
        chk(win_flag == 1'b0, "R8 window flag cleared", win_flag, 0);

        // R2: external pin held high gives exactly one sequence
        trig_sel = 2'd2;
        avg_code = 2'd1;
        clear_flags();
        s0 = start_cnt;
        ext_cnv = 1'b1;
        wait_done();
        repeat (30) @(negedge clk);
        chk(start_cnt - s0 == 4, "R2 held pin single sequence", start_cnt - s0, 4);
        chk(busy == 1'b0, "R2 held pin no retrigger", busy, 0);
        ext_cnv = 1'b0;
        @(negedge clk);

        // R9: accumulator clears between sequences
        trig_sel = 2'd0;
        avg_code = 2'd2;
        clear_flags();
        fire(0);
        wait_done();
        r_first = 0;
        for (int i = 0; i < 8; i++) r_first += sample_of(stub_idx - 8 + i);
        chk(result == 16'(r_first), "R9 first sum", result, r_first);
        clear_flags();
        fire(0);
        wait_done();
        r_first = 0;
        for (int i = 0; i < 8; i++) r_first += sample_of(stub_idx - 8 + i);
        chk(result == 16'(r_first), "R9 sum not carried over", result, r_first);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule